// File: doc/BRIEF.md
# Multi-Lane Serial Flash Command Sequencer

This block carries out one serial flash transaction that the host has set up. A transaction is a chain of phases. It always opens with a command phase. A chaining code can then send it to an address phase, to a write-data phase or to a read-data phase, or end it. The address phase has a chaining code of its own that selects what follows it. Each phase has its own lane width of one, two or four data lanes, and its own cycle count. The cycle count covers the bits the phase carries plus any dummy cycles after them.

The host presents the opcode, a 24-bit address, the cycle counts, the lane codes, the chaining codes, a byte count and the sample-edge choice. A rising edge on `start` begins the transaction. The block copies the whole setup at that moment. Write bytes are first loaded into a transmit FIFO. Read bytes are collected in a receive FIFO, which the host drains. The serial clock runs at half the system clock. Data leaves on the falling serial edge, so it is stable at every rising edge.

Top module: `sflash_seq`

## Requirements
- R1: A transaction is accepted only on a 0-to-1 change of `start` while `busy` is 0. A level held high starts nothing more. A rising edge that arrives while `busy` is 1 is dropped, not queued.
- R2: `busy` reads 0 after reset. It is 1 from the clock after acceptance until the transaction has finished and `cs_n` has returned high.
- R3: `cs_n` is low from the first command cycle to the last cycle of the transaction. Between two transactions it is high for at least one system clock. `sck` is low whenever `cs_n` is high. One serial cycle lasts two system clocks.
- R4: Lane codes 0 and 1 select single lane: output on `io_out[0]`, input on `io_in[1]`. Code 2 selects dual lane on lanes 1..0. Code 3 selects quad lane on lanes 3..0. During driven cycles `io_oe` enables exactly the lanes in use.
- R5: The opcode fills the first 8/w command cycles and the address fills the first 24/w address cycles, where w is the lane count. The cycles after those in each phase are dummy cycles with `io_oe` = 0. `io_oe` is also 0 during every read-data cycle.
- R6: Command chaining code 3'b011 moves on to the address phase, 3'b101 to write data and 3'b110 to read data. Any other value ends the transaction after the command.
- R7: Address chaining code 2'b01 moves on to write data and 2'b10 to read data. Codes 2'b00 and 2'b11 end the transaction after the address.
- R8: The command phase lasts `cmd_len`+1 serial cycles and the address phase `addr_len`+1. A data phase lasts `byte_cnt` × 8/w cycles.
- R9: Fields are shifted most significant bit first. In each cycle the highest-numbered lane in use carries the highest bit.
- R10: When `sample_neg` = 0, read data is captured at the rising `sck` edge. When it is 1, read data is captured at the falling edge. Captured bits are packed MSB first into bytes and pushed into the receive FIFO.
- R11: Each FIFO holds `FIFO_DEPTH` bytes and reports empty and full. A write to a full transmit FIFO is ignored. A write phase pops one byte per byte sent.
- R12: The receive FIFO head (`rx_rdata`) advances on `rx_rd` only while `rx_inc_en` is 1. Otherwise it is left unchanged.
- R13: Every setup input is captured when the transaction is accepted. Changes made while `busy` is 1 do not affect the transaction in progress.
- R14: A data phase selected with `byte_cnt` = 0 is skipped, and the transaction ends after the phase that selected it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start bit; its rising edge requests a transaction |
| opcode | input | 8 | Command opcode |
| addr | input | 24 | Flash byte address |
| cmd_len | input | 6 | Command cycles minus one, dummy cycles included |
| addr_len | input | 6 | Address cycles minus one, dummy cycles included |
| cmd_lanes | input | 2 | Command lane code |
| addr_lanes | input | 2 | Address lane code |
| data_lanes | input | 2 | Data lane code |
| cmd_next | input | 3 | Chaining code after the command |
| addr_next | input | 2 | Chaining code after the address |
| byte_cnt | input | CNT_W | Number of data bytes |
| sample_neg | input | 1 | 1: capture read data on the falling sck edge |
| busy | output | 1 | Transaction in progress |
| tx_wr | input | 1 | Push a byte into the transmit FIFO |
| tx_wdata | input | 8 | Transmit byte |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_rd | input | 1 | Host read of the receive FIFO |
| rx_inc_en | input | 1 | Lets `rx_rd` advance the receive pointer |
| rx_rdata | output | 8 | Receive FIFO head byte |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The case hardest to reach from the ports is the sampling edge. When the flash model holds each value for a whole serial cycle, rising-edge and falling-edge capture return the same byte, so the polarity choice cannot be seen. The bench model therefore changes every lane twice per serial cycle. It presents one pattern value after each falling edge and the inverse of that value after each rising edge. The expected read byte then shows which edge was used. Dummy cycles are covered by a quad command with two dummy cycles and a dual address with four dummy cycles. Per-cycle records of `io_oe` confirm that those cycles leave the lanes released.

// File: rtl/sflash_seq.sv
module sflash_seq #(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [23:0]      addr,
  input  logic [5:0]       cmd_len,
  input  logic [5:0]       addr_len,
  input  logic [1:0]       cmd_lanes,
  input  logic [1:0]       addr_lanes,
  input  logic [1:0]       data_lanes,
  input  logic [2:0]       cmd_next,
  input  logic [1:0]       addr_next,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             sample_neg,
  output logic             busy,
  input  logic             tx_wr,
  input  logic [7:0]       tx_wdata,
  output logic             tx_full,
  output logic             tx_empty,
  input  logic             rx_rd,
  input  logic             rx_inc_en,
  output logic [7:0]       rx_rdata,
  output logic             rx_empty,
  output logic             rx_full,
  output logic             cs_n,
  output logic             sck,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in
);
  localparam int PW = $clog2(FIFO_DEPTH);
  localparam logic [PW:0] FULL_N = FIFO_DEPTH[PW:0];

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_WR, S_RD, S_GAP} state_t;

  function automatic logic [2:0] lanes_of(input logic [1:0] c);
    case (c)
      2'd3:    return 3'd4;
      2'd2:    return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [3:0] cpb_of(input logic [1:0] c);
    case (c)
      2'd3:    return 4'd2;
      2'd2:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  state_t state, nxt;
  logic             ph, start_q;
  logic [31:0]      sh, sh_shifted;
  logic [5:0]       cyc;
  logic [2:0]       bc;
  logic [CNT_W-1:0] left;

  logic [23:0]      l_addr;
  logic [5:0]       l_clen, l_alen;
  logic [1:0]       l_cl, l_al, l_dl, l_an;
  logic [2:0]       l_cn;
  logic [CNT_W-1:0] l_cnt;
  logic             l_neg;

  logic [7:0]  rsh, rnext;
  logic [2:0]  rcnt;

  logic [7:0]  tx_mem [FIFO_DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [PW:0]   tx_cnt;
  logic [7:0]  rx_mem [FIFO_DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [PW:0]   rx_cnt;

  logic [1:0] cur;
  logic [2:0] w;
  logic [3:0] cpb;
  logic active, cyc_end, byte_end, last_byte, phase_last, drive;
  logic load_wr, tx_push, tx_pop, rx_push, rx_pop, samp, accept;
  logic [7:0] tx_byte;
  logic [3:0] lane_mask;

  assign accept    = (state == S_IDLE) && start && !start_q;
  assign cur       = (state == S_CMD) ? l_cl : (state == S_ADDR) ? l_al : l_dl;
  assign w         = lanes_of(cur);
  assign cpb       = cpb_of(cur);
  assign active    = (state == S_CMD) || (state == S_ADDR) || (state == S_WR) || (state == S_RD);
  assign cyc_end   = active && ph;
  assign byte_end  = ({1'b0, bc} == cpb - 4'd1);
  assign last_byte = (left == CNT_W'(1));
  assign phase_last = ((state == S_CMD)  && (cyc == l_clen)) ||
                      ((state == S_ADDR) && (cyc == l_alen)) ||
                      (((state == S_WR) || (state == S_RD)) && byte_end && last_byte);

  always_comb begin
    nxt = S_GAP;
    case (state)
      S_CMD:
        case (l_cn)
          3'b011:  nxt = S_ADDR;
          3'b101:  nxt = (l_cnt != '0) ? S_WR : S_GAP;
          3'b110:  nxt = (l_cnt != '0) ? S_RD : S_GAP;
          default: nxt = S_GAP;
        endcase
      S_ADDR:
        case (l_an)
          2'b01:   nxt = (l_cnt != '0) ? S_WR : S_GAP;
          2'b10:   nxt = (l_cnt != '0) ? S_RD : S_GAP;
          default: nxt = S_GAP;
        endcase
      default: nxt = S_GAP;
    endcase
  end

  assign drive = ((state == S_CMD)  && (cyc < {2'b00, cpb})) ||
                 ((state == S_ADDR) && (cyc < ({2'b00, cpb} + {1'b0, cpb, 1'b0}))) ||
                 (state == S_WR);

  always_comb begin
    case (w)
      3'd4: begin lane_mask = 4'hF; sh_shifted = {sh[27:0], 4'h0}; end
      3'd2: begin lane_mask = 4'h3; sh_shifted = {sh[29:0], 2'h0}; end
      default: begin lane_mask = 4'h1; sh_shifted = {sh[30:0], 1'b0}; end
    endcase
  end

  always_comb begin
    io_out = 4'h0;
    if (drive) begin
      case (w)
        3'd4:    io_out = sh[31:28];
        3'd2:    io_out = {2'b00, sh[31:30]};
        default: io_out = {3'b000, sh[31]};
      endcase
    end
  end

  assign io_oe = drive ? lane_mask : 4'h0;
  assign cs_n  = !active;
  assign sck   = ph;
  assign busy  = (state != S_IDLE);

  assign load_wr = cyc_end && ((phase_last && (nxt == S_WR)) ||
                               ((state == S_WR) && byte_end && !last_byte));
  assign tx_pop  = load_wr && !tx_empty;
  assign tx_byte = tx_empty ? 8'h00 : tx_mem[tx_rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ph      <= 1'b0;
      start_q <= 1'b0;
      sh      <= '0;
      cyc     <= '0;
      bc      <= '0;
      left    <= '0;
      l_addr  <= '0;
      l_clen  <= '0;
      l_alen  <= '0;
      l_cl    <= '0;
      l_al    <= '0;
      l_dl    <= '0;
      l_an    <= '0;
      l_cn    <= '0;
      l_cnt   <= '0;
      l_neg   <= 1'b0;
    end else begin
      start_q <= start;
      case (state)
        S_IDLE: begin
          if (accept) begin
            state  <= S_CMD;
            ph     <= 1'b0;
            cyc    <= '0;
            bc     <= '0;
            sh     <= {opcode, 24'h0};
            l_addr <= addr;
            l_clen <= cmd_len;
            l_alen <= addr_len;
            l_cl   <= cmd_lanes;
            l_al   <= addr_lanes;
            l_dl   <= data_lanes;
            l_cn   <= cmd_next;
            l_an   <= addr_next;
            l_cnt  <= byte_cnt;
            l_neg  <= sample_neg;
          end
        end
        S_GAP: state <= S_IDLE;
        default: begin
          ph <= ~ph;
          if (ph) begin
            if (phase_last) begin
              state <= nxt;
              cyc   <= '0;
              bc    <= '0;
              if (nxt == S_ADDR)    sh <= {l_addr, 8'h0};
              else if (nxt == S_WR) sh <= {tx_byte, 24'h0};
              if ((state == S_CMD) || (state == S_ADDR)) left <= l_cnt;
            end else begin
              cyc <= cyc + 6'd1;
              if ((state == S_WR) || (state == S_RD)) begin
                if (byte_end) begin
                  bc   <= '0;
                  left <= left - CNT_W'(1);
                  if (state == S_WR) sh <= {tx_byte, 24'h0};
                end else begin
                  bc <= bc + 3'd1;
                  sh <= sh_shifted;
                end
              end else begin
                sh <= sh_shifted;
              end
            end
          end
        end
      endcase
    end
  end

  assign samp = (state == S_RD) && (l_neg ? ph : !ph);

  always_comb begin
    case (w)
      3'd4:    rnext = {rsh[3:0], io_in};
      3'd2:    rnext = {rsh[5:0], io_in[1:0]};
      default: rnext = {rsh[6:0], io_in[1]};
    endcase
  end

  assign rx_push = samp && ({1'b0, rcnt} == cpb - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsh  <= '0;
      rcnt <= '0;
    end else if (state == S_IDLE) begin
      rcnt <= '0;
    end else if (samp) begin
      rsh  <= rnext;
      rcnt <= rx_push ? 3'd0 : rcnt + 3'd1;
    end
  end

  assign tx_full  = (tx_cnt == FULL_N);
  assign tx_empty = (tx_cnt == '0);
  assign tx_push  = tx_wr && !tx_full;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= tx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      case ({tx_push, tx_pop})
        2'b10:   tx_cnt <= tx_cnt + 1'b1;
        2'b01:   tx_cnt <= tx_cnt - 1'b1;
        default: tx_cnt <= tx_cnt;
      endcase
    end
  end

  logic rx_in;
  assign rx_full  = (rx_cnt == FULL_N);
  assign rx_empty = (rx_cnt == '0);
  assign rx_in    = rx_push && !rx_full;
  assign rx_pop   = rx_rd && rx_inc_en && !rx_empty;
  assign rx_rdata = rx_mem[rx_rp];

  always_ff @(posedge clk) begin
    if (rx_in) rx_mem[rx_wp] <= rnext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_in)  rx_wp <= rx_wp + 1'b1;
      if (rx_pop) rx_rp <= rx_rp + 1'b1;
      case ({rx_in, rx_pop})
        2'b10:   rx_cnt <= rx_cnt + 1'b1;
        2'b01:   rx_cnt <= rx_cnt - 1'b1;
        default: rx_cnt <= rx_cnt;
      endcase
    end
  end

  a_r1_edge_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start) && !$past(start_q)));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sck));

  a_r3_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

  a_r4_lane_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'h0) || (io_oe == 4'h1) || (io_oe == 4'h3) || (io_oe == 4'hF));

  a_r5_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD) |-> (io_oe == 4'h0));

  a_r11_tx_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty));

  a_r11_rx_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_full && rx_empty));

  a_r12_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_empty && !(rx_rd && rx_inc_en)) |=> $stable(rx_rdata));
endmodule

// File: tb/sflash_seq_tb_top.sv
`timescale 1ns/1ps
module sflash_seq_tb_top;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [23:0] addr = '0;
  logic [5:0]  cmd_len = '0, addr_len = '0;
  logic [1:0]  cmd_lanes = '0, addr_lanes = '0, data_lanes = '0, addr_next = '0;
  logic [2:0]  cmd_next = '0;
  logic [7:0]  byte_cnt = '0;
  logic        sample_neg = 1'b0;
  logic        busy;
  logic        tx_wr = 1'b0;
  logic [7:0]  tx_wdata = '0;
  logic        tx_full, tx_empty;
  logic        rx_rd = 1'b0, rx_inc_en = 1'b0;
  logic [7:0]  rx_rdata;
  logic        rx_empty, rx_full;
  logic        cs_n, sck;
  logic [3:0]  io_out, io_oe;
  logic [3:0]  io_in = '0;

  sflash_seq #(.FIFO_DEPTH(DEPTH), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .addr(addr),
    .cmd_len(cmd_len), .addr_len(addr_len), .cmd_lanes(cmd_lanes),
    .addr_lanes(addr_lanes), .data_lanes(data_lanes), .cmd_next(cmd_next),
    .addr_next(addr_next), .byte_cnt(byte_cnt), .sample_neg(sample_neg),
    .busy(busy), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_full(tx_full),
    .tx_empty(tx_empty), .rx_rd(rx_rd), .rx_inc_en(rx_inc_en),
    .rx_rdata(rx_rdata), .rx_empty(rx_empty), .rx_full(rx_full),
    .cs_n(cs_n), .sck(sck), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  int n_chk = 0;
  int n_bad = 0;
  int ncyc = 0;
  logic cs_d = 1'b1;
  logic sck_d = 1'b0;
  logic [3:0] ro  [256];
  logic [3:0] roe [256];

  function automatic logic [3:0] pat(int c);
    return 4'(c * 5 + 9);
  endfunction

  always @(cs_n or sck) begin
    if (cs_d && !cs_n) begin
      ncyc = 0;
      io_in = pat(0);
    end else if (!sck_d && sck) begin
      if (ncyc < 256) begin
        ro[ncyc]  = io_out;
        roe[ncyc] = io_oe;
      end
      io_in = pat(ncyc) ^ 4'hF;
    end else if (sck_d && !sck) begin
      ncyc = ncyc + 1;
      io_in = pat(ncyc);
    end
    cs_d  = cs_n;
    sck_d = sck;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gather(int s, int n, int w);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) begin
      case (w)
        4:       r = {r[27:0], ro[s+i]};
        2:       r = {r[29:0], ro[s+i][1:0]};
        default: r = {r[30:0], ro[s+i][0]};
      endcase
    end
    return r;
  endfunction

  function automatic int oe_bad(int s, int n, logic [3:0] m);
    int b = 0;
    for (int i = 0; i < n; i++) if (roe[s+i] !== m) b++;
    return b;
  endfunction

  function automatic logic [7:0] exp_rx(int k, int w, bit inv);
    logic [7:0] b = '0;
    for (int i = 0; i < 8 / w; i++) begin
      logic [3:0] v;
      v = pat(k + i) ^ (inv ? 4'hF : 4'h0);
      case (w)
        4:       b = {b[3:0], v};
        2:       b = {b[5:0], v[1:0]};
        default: b = {b[6:0], v[1]};
      endcase
    end
    return b;
  endfunction

  task automatic run_txn();
    @(negedge clk) start = 1'b1;
    @(negedge clk);
    chk("R2 busy after accept", 32'(busy), 32'd1);
    chk("R3 cs_n low in first cycle", 32'(cs_n), 32'd0);
    while (busy) @(negedge clk);
    chk("R3 cs_n high after finish", 32'(cs_n), 32'd1);
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic push_tx(logic [7:0] b);
    @(negedge clk);
    tx_wr = 1'b1;
    tx_wdata = b;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic pop_rx(string req, logic [7:0] exp);
    chk(req, {24'h0, rx_rdata}, {24'h0, exp});
    rx_rd = 1'b1;
    rx_inc_en = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    rx_inc_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R2 busy at reset", 32'(busy), 32'd0);
    chk("R3 cs_n at reset", 32'(cs_n), 32'd1);
    chk("R3 sck at reset", 32'(sck), 32'd0);
    chk("R11 tx_empty at reset", 32'(tx_empty), 32'd1);
    chk("R11 rx_empty at reset", 32'(rx_empty), 32'd1);
    chk("R4 io_oe at reset", 32'(io_oe), 32'd0);
  endtask

  task automatic t_cmd_only();
    opcode = 8'h9F; cmd_lanes = 2'd1; cmd_len = 6'd7; cmd_next = 3'b000; byte_cnt = 8'd4;
    run_txn();
    chk("R6 other code ends after command (cycles)", 32'(ncyc), 32'd8);
    chk("R9 opcode MSB first single lane", gather(0, 8, 1), 32'h9F);
    chk("R4 single lane enable", 32'(oe_bad(0, 8, 4'h1)), 32'd0);
  endtask

  task automatic t_quad_write();
    push_tx(8'hA5); push_tx(8'h3C); push_tx(8'h7E);
    opcode = 8'h32; cmd_lanes = 2'd0; cmd_len = 6'd7; cmd_next = 3'b011;
    addr = 24'h12A5C3; addr_lanes = 2'd3; addr_len = 6'd5; addr_next = 2'b01;
    data_lanes = 2'd3; byte_cnt = 8'd3;
    run_txn();
    chk("R8 cycle count cmd+addr+write", 32'(ncyc), 32'd20);
    chk("R9 quad address nibbles", gather(8, 6, 4), 32'h0012A5C3);
    chk("R9 quad write data order", gather(14, 6, 4), 32'h00A53C7E);
    chk("R4 quad enables addr+data", 32'(oe_bad(8, 12, 4'hF)), 32'd0);
    chk("R11 write phase drained tx", 32'(tx_empty), 32'd1);
  endtask

  task automatic t_dual_read();
    opcode = 8'hBB; cmd_lanes = 2'd3; cmd_len = 6'd3; cmd_next = 3'b011;
    addr = 24'h5A0F96; addr_lanes = 2'd2; addr_len = 6'd15; addr_next = 2'b10;
    data_lanes = 2'd2; byte_cnt = 8'd2; sample_neg = 1'b0;
    run_txn();
    chk("R8 cycle count with dummies", 32'(ncyc), 32'd28);
    chk("R4 quad opcode", gather(0, 2, 4), 32'hBB);
    chk("R5 command dummy released", 32'(oe_bad(2, 2, 4'h0)), 32'd0);
    chk("R4 dual address", gather(4, 12, 2), 32'h005A0F96);
    chk("R4 dual address enables", 32'(oe_bad(4, 12, 4'h3)), 32'd0);
    chk("R5 address dummy released", 32'(oe_bad(16, 4, 4'h0)), 32'd0);
    chk("R5 read cycles released", 32'(oe_bad(20, 8, 4'h0)), 32'd0);
    pop_rx("R10 rising-edge dual byte 0", exp_rx(20, 2, 1'b0));
    pop_rx("R10 rising-edge dual byte 1", exp_rx(24, 2, 1'b0));
    chk("R11 rx empty after drain", 32'(rx_empty), 32'd1);
  endtask

  task automatic t_single_read_neg();
    opcode = 8'h03; cmd_lanes = 2'd0; cmd_len = 6'd7; cmd_next = 3'b110;
    data_lanes = 2'd0; byte_cnt = 8'd2; sample_neg = 1'b1;
    run_txn();
    chk("R6 code 110 goes straight to read", 32'(ncyc), 32'd24);
    pop_rx("R10 falling-edge single byte 0", exp_rx(8, 1, 1'b1));
    pop_rx("R10 falling-edge single byte 1", exp_rx(16, 1, 1'b1));
    sample_neg = 1'b0;
  endtask

  task automatic t_rx_inc();
    opcode = 8'h03; cmd_lanes = 2'd0; cmd_len = 6'd7; cmd_next = 3'b110;
    data_lanes = 2'd1; byte_cnt = 8'd2; sample_neg = 1'b0;
    run_txn();
    rx_inc_en = 1'b0;
    rx_rd = 1'b1;
    repeat (3) @(negedge clk);
    rx_rd = 1'b0;
    @(negedge clk);
    chk("R12 head held without increment enable", {24'h0, rx_rdata}, {24'h0, exp_rx(8, 1, 1'b0)});
    chk("R12 fifo not drained without enable", 32'(rx_empty), 32'd0);
    pop_rx("R12 first byte", exp_rx(8, 1, 1'b0));
    pop_rx("R12 second byte after advance", exp_rx(16, 1, 1'b0));
    chk("R12 empty after two advances", 32'(rx_empty), 32'd1);
  endtask

  task automatic t_addr_end();
    opcode = 8'h20; cmd_lanes = 2'd0; cmd_len = 6'd7; cmd_next = 3'b011;
    addr = 24'h000100; addr_lanes = 2'd0; addr_len = 6'd23; addr_next = 2'b11;
    byte_cnt = 8'd5;
    run_txn();
    chk("R7 code 11 ends after address", 32'(ncyc), 32'd32);
    chk("R7 nothing received", 32'(rx_empty), 32'd1);
    chk("R9 single lane address", gather(8, 24, 1), 32'h00000100);
  endtask

  task automatic t_zero_cnt();
    opcode = 8'h06; cmd_lanes = 2'd0; cmd_len = 6'd7; cmd_next = 3'b110; byte_cnt = 8'd0;
    run_txn();
    chk("R14 zero count skips read phase", 32'(ncyc), 32'd8);
    chk("R14 no byte received", 32'(rx_empty), 32'd1);
  endtask

  task automatic t_edge();
    int starts;
    opcode = 8'hAB; cmd_lanes = 2'd0; cmd_len = 6'd7; cmd_next = 3'b000;
    @(negedge clk) start = 1'b1;
    @(negedge clk);
    while (busy) @(negedge clk);
    starts = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy || !cs_n) starts++;
    end
    chk("R1 held level starts nothing", 32'(starts), 32'd0);
    start = 1'b0;
    @(negedge clk) start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk);
    chk("R1 first transaction still busy", 32'(busy), 32'd1);
    while (busy) @(negedge clk);
    starts = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (busy) starts++;
    end
    chk("R1 edge during busy dropped", 32'(starts), 32'd0);
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_latch();
    opcode = 8'hC7; cmd_lanes = 2'd0; cmd_len = 6'd7; cmd_next = 3'b000;
    @(negedge clk) start = 1'b1;
    @(negedge clk);
    opcode = 8'h00; cmd_len = 6'd3; cmd_next = 3'b011; cmd_lanes = 2'd3;
    while (busy) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R13 length captured at accept", 32'(ncyc), 32'd8);
    chk("R13 opcode captured at accept", gather(0, 8, 1), 32'hC7);
  endtask

  task automatic t_fifo_full();
    for (int i = 0; i < DEPTH; i++) push_tx(8'(8'h10 + i));
    chk("R11 tx full at depth", 32'(tx_full), 32'd1);
    push_tx(8'hEE);
    opcode = 8'h38; cmd_lanes = 2'd0; cmd_len = 6'd7; cmd_next = 3'b101;
    data_lanes = 2'd3; byte_cnt = 8'(DEPTH);
    run_txn();
    chk("R8 write-only cycle count", 32'(ncyc), 32'(8 + 2 * DEPTH));
    for (int i = 0; i < DEPTH; i++)
      chk("R11 bytes sent in order", gather(8 + 2 * i, 2, 4), 32'(8'h10 + i));
    chk("R11 write to full fifo ignored", 32'(tx_empty), 32'd1);
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_cmd_only();
    t_quad_write();
    t_dual_read();
    t_single_read_neg();
    t_rx_inc();
    t_addr_end();
    t_zero_cnt();
    t_edge();
    t_latch();
    t_fifo_full();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule